// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Processor Bus Port

This block is the digital sequencer of an 8-bit successive-approximation converter that is attached to a microprocessor bus. The bus side has three active-low strobes: chip select, write and read. When select and write are both low, the converter is held in a clear state. Releasing either strobe starts a conversion after a short synchronising delay. The block then presents a trial code to an external ladder or DAC and samples a one-bit comparator answer for each bit, starting with the most significant bit and ending with the least significant bit.

Each bit decision occupies a fixed slot of clock cycles. When all bits are decided, the result is copied into an output register and an active-low interrupt is raised. A bus read with select and read low places the stored word on the data bus, enables the bus drivers and clears the interrupt.

If the interrupt output is wired back to the write strobe and select is held low, the block converts continuously.

Top module: `sar_bus_ctl`

## Requirements
- R1: While `cs_n` and `wr_n` are both low, `trial` reads 0, `intr_n` stays high and no conversion completes, however long the condition lasts.
- R2: If the select-and-write hold has lasted at least 9 clocks, the first trial code 0x80 appears on `trial` between 1 and 8 clock cycles after the hold is released.
- R3: Bits are decided from the MSB down to the LSB, one per 8-clock slot. Each slot sets its bit tentatively and samples `cmp` on the slot's last clock: `cmp`=1 keeps the bit and `cmp`=0 clears it. `intr_n` falls exactly 65 clocks after the first trial code appears.
- R4: The stored result is the input level clamped to 0..255, with `cmp`=1 meaning input >= trial. A full-scale input gives 0xFF, and an input at or below zero gives 0x00.
- R5: `intr_n` is high for the whole conversion and goes low in the cycle the result is stored.
- R6: With `cs_n` and `rd_n` both low, `db_oe` is 1 and `db_out` shows the stored word in the same cycle, and `intr_n` is high after the next clock. When the read ends, `db_oe` is 0, `db_out` is 0 and `intr_n` stays high.
- R7: If a conversion completes while a read is active, completion takes priority for that clock, so `intr_n` is low for exactly one cycle.
- R8: With `intr_n` fed back to `wr_n` and `cs_n` held low, conversions repeat without further stimulus, and each one stores the correct result.
- R9: After the synchronous reset `rst`, `intr_n` is high, `db_oe` is 0 and `trial` is 0, and nothing happens until a write strobe arrives.
- R10: A select-and-write hold during a conversion aborts it. The previously stored word stays readable, and a new conversion starts when the hold ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; holds and restarts conversion |
| rd_n | input | 1 | Read strobe, active low |
| cmp | input | 1 | Comparator answer: 1 when input >= trial code |
| trial | output | DATA_W | Trial code driven to the ladder |
| intr_n | output | 1 | Conversion-done interrupt, active low |
| db_out | output | DATA_W | Data bus value (0 when not driven) |
| db_oe | output | 1 | Data bus driver enable |

## Verification
The bench targets these corner cases:

- **Start delay.** It measures the delay from releasing the strobe to the first trial code. A start synchroniser that skipped or doubled a slot edge would fall outside the 1 to 8 clock window.
- **Completion timing.** It counts clocks up to the interrupt. A slot decoder that was off by one would miss the figure of 65.
- **Input extremes.** Negative inputs and over-range inputs check that the result clamps to 0x00 and 0xFF. A wrong comparator sense would invert the codes.
- **Read during completion.** A read held across the end of a conversion shows whether a completion is lost when the read clear wins the same clock.
- **Abort and free running.** A mid-conversion hold must leave the previous result readable. The feedback loop must restart itself instead of stalling after its first interrupt.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
   parameter int unsigned SAR_W_DEF  = 8;   // result width
   parameter int unsigned SLOT_DEF   = 8;   // clocks per bit decision
   parameter int unsigned SLOT_MIN   = 2;
   parameter int unsigned SAR_W_MIN  = 2;
endpackage

// File: rtl/sar_start_sync.sv
// Slot divider plus two-stage start synchroniser.
module sar_start_sync #(
   parameter int unsigned SLOT_CLKS = sar_ctl_pkg::SLOT_DEF
) (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   output logic tick,
   output logic inject
);
   localparam int unsigned CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOT_CLKS - 1);

   logic [CW-1:0] div_q;
   logic          arm_q;
   logic          sync_q;

   assign tick   = (div_q == LAST);
   assign inject = tick && !hold && arm_q && sync_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         arm_q  <= 1'b0;
         sync_q <= 1'b0;
      end else if (hold) begin
         arm_q <= 1'b1;
         if (tick) sync_q <= arm_q;
      end else if (tick) begin
         if (arm_q && sync_q) begin
            arm_q  <= 1'b0;
            sync_q <= 1'b0;
         end else begin
            sync_q <= arm_q;
         end
      end
   end
endmodule

// File: rtl/sar_bit_stepper.sv
// Walking-one step register and successive-approximation register.
module sar_bit_stepper #(
   parameter int unsigned DATA_W = sar_ctl_pkg::SAR_W_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic              tick,
   input  logic              inject,
   input  logic              cmp,
   output logic [DATA_W-1:0] trial,
   output logic              busy,
   output logic              fin
);
   localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] step_q;
   logic [DATA_W-1:0] sar_q;
   logic [DATA_W-1:0] sar_d;

   // per-bit next value: decide the active bit, tentatively set the next one
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi == DATA_W - 1) begin : g_top
         assign sar_d[gi] = step_q[gi] ? cmp : sar_q[gi];
      end else begin : g_low
         assign sar_d[gi] = step_q[gi] ? cmp : (step_q[gi+1] ? 1'b1 : sar_q[gi]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || hold) begin
         step_q <= '0;
         sar_q  <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= tick && step_q[0];
         if (inject) begin
            step_q <= MSB_ONE;
            sar_q  <= MSB_ONE;
         end else if (tick && (|step_q)) begin
            step_q <= step_q >> 1;
            sar_q  <= sar_d;
         end
      end
   end

   assign trial = sar_q;
   assign busy  = |step_q;
endmodule

// File: rtl/sar_out_latch.sv
// Result register and interrupt flip-flop.
module sar_out_latch #(
   parameter int unsigned DATA_W = sar_ctl_pkg::SAR_W_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic              fin,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] latch_q,
   output logic              irq_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         latch_q <= '0;
      end else if (fin) begin
         latch_q <= word;
      end
   end

   // completion outranks the read clear; a hold outranks both
   always_ff @(posedge clk) begin
      if (rst || hold) begin
         irq_q <= 1'b0;
      end else if (fin) begin
         irq_q <= 1'b1;
      end else if (rd_sel) begin
         irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sar_bus_ctl.sv
module sar_bus_ctl #(
   parameter int unsigned DATA_W    = sar_ctl_pkg::SAR_W_DEF,
   parameter int unsigned SLOT_CLKS = sar_ctl_pkg::SLOT_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              cmp,
   output logic [DATA_W-1:0] trial,
   output logic              intr_n,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe
);
   if (DATA_W < sar_ctl_pkg::SAR_W_MIN) begin : g_bad_w
      $error("sar_bus_ctl: DATA_W too small");
   end
   if (SLOT_CLKS < sar_ctl_pkg::SLOT_MIN) begin : g_bad_slot
      $error("sar_bus_ctl: SLOT_CLKS too small");
   end

   logic              hold;
   logic              rd_sel;
   logic              tick;
   logic              inject;
   logic              busy;
   logic              fin;
   logic              irq_q;
   logic [DATA_W-1:0] latch_q;

   assign hold   = !cs_n && !wr_n;
   assign rd_sel = !cs_n && !rd_n;

   sar_start_sync #(.SLOT_CLKS(SLOT_CLKS)) u_start (
      .clk(clk), .rst(rst), .hold(hold), .tick(tick), .inject(inject)
   );

   sar_bit_stepper #(.DATA_W(DATA_W)) u_step (
      .clk(clk), .rst(rst), .hold(hold), .tick(tick), .inject(inject),
      .cmp(cmp), .trial(trial), .busy(busy), .fin(fin)
   );

   sar_out_latch #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .hold(hold), .fin(fin), .rd_sel(rd_sel),
      .word(trial), .latch_q(latch_q), .irq_q(irq_q)
   );

   assign intr_n = !irq_q;
   assign db_oe  = rd_sel;
   assign db_out = rd_sel ? latch_q : '0;
endmodule

// File: rtl/sar_bus_ctl_chk.sv
module sar_bus_ctl_chk #(
   parameter int unsigned DATA_W = sar_ctl_pkg::SAR_W_DEF
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              wr_n,
   input logic              rd_n,
   input logic [DATA_W-1:0] trial,
   input logic              intr_n,
   input logic [DATA_W-1:0] db_out,
   input logic              db_oe,
   input logic              busy,
   input logic              fin
);
   localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

   p_hold_clears_r1: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !wr_n) |=> (trial == '0 && intr_n));

   p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (trial == MSB_ONE));

   p_done_raises_r5: assert property (@(posedge clk) disable iff (rst)
      (fin && !(!cs_n && !wr_n)) |=> !intr_n);

   p_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !intr_n |-> !busy);

   p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !rd_n && !fin) |=> intr_n);

   p_bus_steady_r6: assert property (@(posedge clk) disable iff (rst)
      (db_oe && $past(db_oe) && !$past(fin)) |-> $stable(db_out));
endmodule

bind sar_bus_ctl sar_bus_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
   .trial(trial), .intr_n(intr_n), .db_out(db_out), .db_oe(db_oe),
   .busy(busy), .fin(fin)
);

// File: tb/sar_bus_ctl_tb.sv
`timescale 1ns/1ps
module sar_bus_ctl_tb;
   localparam int NV = 9;
   localparam int VEC_IN  [NV] = '{0, -5, 255, 300, 128, 127, 1, 165, 77};
   localparam int VEC_EXP [NV] = '{0,  0, 255, 255, 128, 127, 1, 165, 77};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1;
   logic       wr_tb = 1'b1;
   logic       rd_n = 1'b1;
   logic       fr = 1'b0;
   logic       wr_n_dut;
   logic       cmp;
   logic [7:0] trial;
   logic       intr_n;
   logic [7:0] db_out;
   logic       db_oe;
   int         vin = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   assign wr_n_dut = fr ? intr_n : wr_tb;
   assign cmp = (vin >= int'(trial));

   sar_bus_ctl u_dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n_dut), .rd_n(rd_n),
      .cmp(cmp), .trial(trial), .intr_n(intr_n), .db_out(db_out), .db_oe(db_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic run_conv(input int v, output int t_first, output int f_val, output int t_done);
      vin = v;
      @(negedge clk); cs_n = 1'b0; wr_tb = 1'b0; rd_n = 1'b1;
      repeat (10) @(negedge clk);
      wr_tb = 1'b1;
      t_first = 0;
      do begin
         @(negedge clk); t_first++;
      end while (trial == 8'd0 && t_first < 40);
      f_val = int'(trial);
      t_done = 0;
      while (intr_n && t_done < 200) begin
         @(negedge clk); t_done++;
      end
   endtask

   task automatic bus_read(output int d, output int oe, output int irq_after,
                           output int oe_off, output int d_off);
      @(negedge clk); rd_n = 1'b0;
      #1; d = int'(db_out); oe = int'(db_oe);
      @(negedge clk); irq_after = int'(intr_n);
      rd_n = 1'b1;
      #1; oe_off = int'(db_oe); d_off = int'(db_out);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int tf, fv, td, d, oe, ia, oo, dd, bad, lows;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      // R9: idle after reset, no write strobe
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (!intr_n || trial != 8'd0 || db_oe) bad++;
      end
      chk("R9 idle after reset", bad, 0);
      chk("R9 intr_n reset", int'(intr_n), 1);

      // vector table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         run_conv(VEC_IN[i], tf, fv, td);
         chk_rng("R2 start delay", tf, 1, 8);
         chk("R3 first trial", fv, 128);
         chk("R3 R5 clocks to done", td, 65);
         bus_read(d, oe, ia, oo, dd);
         chk("R4 result", d, VEC_EXP[i]);
         chk("R6 bus enable", oe, 1);
         chk("R6 irq cleared", ia, 1);
         chk("R6 bus released", oo * 256 + dd, 0);
      end
      @(negedge clk);
      chk("R6 irq stays clear", int'(intr_n), 1);

      // R1: long hold
      @(negedge clk); cs_n = 1'b0; wr_tb = 1'b0; vin = 255;
      bad = 0;
      repeat (100) begin
         @(negedge clk);
         if (trial != 8'd0 || !intr_n) bad++;
      end
      chk("R1 long hold", bad, 0);

      // R10: abort mid conversion keeps old result
      run_conv(200, tf, fv, td);
      bus_read(d, oe, ia, oo, dd);
      chk("R10 first result", d, 200);
      vin = 50;
      @(negedge clk); wr_tb = 1'b0;
      repeat (10) @(negedge clk);
      wr_tb = 1'b1;
      repeat (30) @(negedge clk);
      wr_tb = 1'b0; rd_n = 1'b0;
      repeat (12) @(negedge clk);
      chk("R1 abort clears trial", int'(trial), 0);
      chk("R10 irq high on abort", int'(intr_n), 1);
      chk("R10 old word readable", int'(db_out), 200);
      rd_n = 1'b1; wr_tb = 1'b1;
      td = 0;
      while (intr_n && td < 200) begin
         @(negedge clk); td++;
      end
      chk_rng("R10 restart completes", td, 66, 73);
      bus_read(d, oe, ia, oo, dd);
      chk("R10 new result", d, 50);

      // R7: read held across completion
      vin = 33;
      @(negedge clk); wr_tb = 1'b0;
      repeat (10) @(negedge clk);
      wr_tb = 1'b1; rd_n = 1'b0;
      lows = 0;
      repeat (100) begin
         @(negedge clk);
         if (!intr_n) lows++;
      end
      chk("R7 one-cycle irq pulse", lows, 1);
      chk("R7 word on bus", int'(db_out), 33);
      rd_n = 1'b1;

      // R8: free running
      vin = 99;
      @(negedge clk); wr_tb = 1'b0;
      repeat (10) @(negedge clk);
      wr_tb = 1'b1; fr = 1'b1;
      lows = 0;
      repeat (500) begin
         @(negedge clk);
         if (!intr_n) lows++;
      end
      chk_rng("R8 repeated conversions", lows, 5, 8);
      fr = 1'b0;
      td = 0;
      while (intr_n && td < 200) begin
         @(negedge clk); td++;
      end
      bus_read(d, oe, ia, oo, dd);
      chk("R8 free-run result", d, 99);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule